// File: doc/BRIEF.md
# I2C Dual-Address Slave Front End

This block is the byte-level engine of an I2C slave that answers two bus addresses, each set by its own 7-bit input. The memory address forwards each data byte to a local request/response port. That port stands in for a master on the system bus. The configuration address reaches one 8-bit register. The register holds a small control field and three status flags that report on the local side. The block takes SCL and SDA that have already been synchronized and filtered. It drives each line only by pulling it low, through two enable outputs, and samples data on rising SCL edges. It changes what it drives only while SCL is low.

A write to the memory address sends one local request per data byte. A read sends a request when the address is accepted, and another after each byte the master acknowledges. The returned byte is shifted out MSB first. A slow local side can hold SCL low at the end of an acknowledge clock until its response arrives. This stretching can be turned on or off with an input.

Top module: `i2c_dual_slave`

## Requirements
- R1: The first byte after a START holds the 7-bit address in bits 7:1 and the direction in bit 0 (0 = master writes, 1 = master reads). If the address equals `cfg_addr_i`, or equals `mem_addr_i` and the no-acknowledge control is clear, the slave pulls SDA low for the ninth clock.
- R2: If the address matches neither input, SDA stays released during the ninth clock. Until the next START or STOP the slave then drives neither line and issues no local request.
- R3: Each data byte written to the configuration address stores its bits 2:0 into the control field. Bits 7:3 of the written byte have no effect on what is read back, and bits 7:6 of the register always read 0.
- R4: A read from the configuration address returns, MSB first, {2'b00, window fault, error fault, busy, no-ack control, size[1:0]}.
- R5: The window fault flag (bit 5) and the error fault flag (bit 4) are replaced on every local response by that response's `rsp_prot_i` and `rsp_err_i`.
- R6: The busy flag (bit 3) is 1 from the cycle a local request is issued until the cycle after its response.
- R7: Every data byte written to the memory address is acknowledged. It produces exactly one single-cycle `req_valid_o` pulse with `req_write_o` = 1, the byte on `req_wdata_o`, and the size field on `req_size_o` (00 byte, 01 halfword, 10 word).
- R8: A memory-address read issues a read request when the address is accepted and after each byte the master acknowledges. Each returned `rsp_rdata_i` byte is sent MSB first. A master not-acknowledge ends the transfer.
- R9: While control bit 2 is 1, the memory address is not acknowledged. The configuration address still is.
- R10: With `stretch_en_i` = 1, if a local request is outstanding at the falling edge that ends an acknowledge clock, the slave holds SCL low until the response has arrived. With `stretch_en_i` = 0 it never holds SCL.
- R11: A repeated START at any point returns the slave to address reception and releases both lines. A STOP returns it to idle.
- R12: After reset both lines are released, no request is pending, and the configuration register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized, filtered SCL level |
| sda_i | input | 1 | Synchronized, filtered SDA level |
| scl_oe_o | output | 1 | 1 pulls SCL low (stretching) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| mem_addr_i | input | 7 | Bus address routed to the local port |
| cfg_addr_i | input | 7 | Bus address of the configuration register |
| stretch_en_i | input | 1 | Enables SCL stretching |
| req_valid_o | output | 1 | Single-cycle local request strobe |
| req_write_o | output | 1 | 1 = write request, 0 = read request |
| req_wdata_o | output | 8 | Byte to write |
| req_size_o | output | 2 | Access size from the control field |
| rsp_valid_i | input | 1 | Local response strobe |
| rsp_rdata_i | input | 8 | Byte returned for a read |
| rsp_err_i | input | 1 | Response reported an error |
| rsp_prot_i | input | 1 | Access fell outside the permitted window |

## Verification
The assertions check properties that hold on every cycle. Each local request is one cycle long and is always covered by the busy flag. The fault flags follow the latest response. A START always releases both lines. SCL is let go whenever stretching is switched off. Only the bench's bus scenarios can show that address matching is right, that the ninth-clock acknowledge and not-acknowledge land where they should, that bytes arrive MSB first in the right order, and that the bus stays silent after a mismatch. They also show a repeated START changing target mid-transfer, and stretching that stalls a real master and still delivers the right read data.

// File: rtl/i2c_dual_pkg.sv
package i2c_dual_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_TXACK, ST_HOLD, ST_IGNORE
    } fsm_e;

    typedef enum logic [1:0] {TGT_NONE, TGT_CFG, TGT_MEM} tgt_e;

    localparam int CFG_WIN_BIT  = 5;
    localparam int CFG_ERR_BIT  = 4;
    localparam int CFG_BUSY_BIT = 3;
    localparam int CFG_NACK_BIT = 2;
endpackage

// File: rtl/i2c_line_edges.sv
module i2c_line_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o,
    output logic sda_s_o
);
    typedef struct packed {
        logic scl1;
        logic scl2;
        logic sda1;
        logic sda2;
    } edge_t;

    edge_t e_d, e_q;

    always_comb begin
        e_d      = e_q;
        e_d.scl1 = scl_i;
        e_d.scl2 = e_q.scl1;
        e_d.sda1 = sda_i;
        e_d.sda2 = e_q.sda1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '{scl1: 1'b1, scl2: 1'b1, sda1: 1'b1, sda2: 1'b1};
        else        e_q <= e_d;
    end

    assign scl_rise_o = e_q.scl1 & ~e_q.scl2;
    assign scl_fall_o = ~e_q.scl1 & e_q.scl2;
    assign start_o    = e_q.scl1 & e_q.scl2 & e_q.sda2 & ~e_q.sda1;
    assign stop_o     = e_q.scl1 & e_q.scl2 & ~e_q.sda2 & e_q.sda1;
    assign sda_s_o    = e_q.sda1;
endmodule

// File: rtl/i2c_cfg_store.sv
module i2c_cfg_store import i2c_dual_pkg::*; #(
    parameter int REG_W  = 8,
    parameter int CTL_W  = 3,
    parameter int SIZE_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [CTL_W-1:0] wr_ctl_i,
    input  logic             busy_i,
    input  logic             rsp_valid_i,
    input  logic             rsp_err_i,
    input  logic             rsp_prot_i,
    output logic [REG_W-1:0] value_o,
    output logic             nack_o,
    output logic [SIZE_W-1:0] size_o
);
    localparam int RSV_W = REG_W - CFG_WIN_BIT - 1;

    typedef struct packed {
        logic             win;
        logic             err;
        logic [CTL_W-1:0] ctl;
    } cfg_t;

    cfg_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (wr_en_i) c_d.ctl = wr_ctl_i;
        if (rsp_valid_i) begin
            c_d.win = rsp_prot_i;
            c_d.err = rsp_err_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign value_o = {{RSV_W{1'b0}}, c_q.win, c_q.err, busy_i, c_q.ctl};
    assign nack_o  = c_q.ctl[CFG_NACK_BIT];
    assign size_o  = c_q.ctl[SIZE_W-1:0];

    // R5
    flag_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_i |=> (value_o[CFG_WIN_BIT] == $past(rsp_prot_i)) &&
                        (value_o[CFG_ERR_BIT] == $past(rsp_err_i)));

    // R3
    ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (value_o[CTL_W-1:0] == $past(wr_ctl_i)));
endmodule

// File: rtl/i2c_dual_slave.sv
module i2c_dual_slave import i2c_dual_pkg::*; #(
    parameter int ADDR_W = 7,
    parameter int BYTE_W = 8,
    parameter int SIZE_W = 2,
    parameter int CTL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe_o,
    output logic              sda_oe_o,
    input  logic [ADDR_W-1:0] mem_addr_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic              stretch_en_i,
    output logic              req_valid_o,
    output logic              req_write_o,
    output logic [BYTE_W-1:0] req_wdata_o,
    output logic [SIZE_W-1:0] req_size_o,
    input  logic              rsp_valid_i,
    input  logic [BYTE_W-1:0] rsp_rdata_i,
    input  logic              rsp_err_i,
    input  logic              rsp_prot_i
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        fsm_e              st;
        tgt_e              tgt;
        logic              rw;
        logic              addr_ph;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic              sda_oe;
        logic              scl_oe;
        logic              m_ack;
        logic              req_v;
        logic              req_w;
        logic [BYTE_W-1:0] req_d;
        logic              busy;
        logic [BYTE_W-1:0] rd;
        logic              cfg_we;
    } regs_t;

    regs_t r_d, r_q;

    logic scl_rise, scl_fall, start_det, stop_det, sda_s;
    logic [BYTE_W-1:0] cfg_val;
    logic              cfg_nack;
    logic [SIZE_W-1:0] cfg_size;

    i2c_line_edges u_edges (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det),
        .sda_s_o    (sda_s)
    );

    i2c_cfg_store #(.REG_W(BYTE_W), .CTL_W(CTL_W), .SIZE_W(SIZE_W)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (r_q.cfg_we),
        .wr_ctl_i    (r_q.sh[CTL_W-1:0]),
        .busy_i      (r_q.busy),
        .rsp_valid_i (rsp_valid_i),
        .rsp_err_i   (rsp_err_i),
        .rsp_prot_i  (rsp_prot_i),
        .value_o     (cfg_val),
        .nack_o      (cfg_nack),
        .size_o      (cfg_size)
    );

    logic [ADDR_W-1:0] rx_addr;
    logic [BYTE_W-1:0] tx_byte;
    logic              stall, adv, hold;

    assign rx_addr = r_q.sh[BYTE_W-1 -: ADDR_W];
    assign tx_byte = (r_q.tgt == TGT_CFG) ? cfg_val : r_q.rd;
    assign stall   = stretch_en_i & r_q.busy;

    always_comb begin
        r_d        = r_q;
        r_d.req_v  = 1'b0;
        r_d.cfg_we = 1'b0;
        adv        = 1'b0;
        hold       = 1'b0;

        if (rsp_valid_i) begin
            r_d.busy = 1'b0;
            if (!r_q.req_w) r_d.rd = rsp_rdata_i;
        end

        case (r_q.st)
            ST_RX: begin
                if (scl_rise && r_q.cnt != CNT_FULL) begin
                    r_d.sh  = {r_q.sh[BYTE_W-2:0], sda_s};
                    r_d.cnt = r_q.cnt + 1'b1;
                end else if (scl_fall && r_q.cnt == CNT_FULL) begin
                    if (r_q.addr_ph) begin
                        r_d.addr_ph = 1'b0;
                        r_d.rw      = r_q.sh[0];
                        if (rx_addr == cfg_addr_i) begin
                            r_d.tgt    = TGT_CFG;
                            r_d.st     = ST_ACK;
                            r_d.sda_oe = 1'b1;
                        end else if (rx_addr == mem_addr_i && !cfg_nack) begin
                            r_d.tgt    = TGT_MEM;
                            r_d.st     = ST_ACK;
                            r_d.sda_oe = 1'b1;
                            if (r_q.sh[0] && !r_q.busy) begin
                                r_d.req_v = 1'b1;
                                r_d.req_w = 1'b0;
                                r_d.busy  = 1'b1;
                            end
                        end else begin
                            r_d.tgt = TGT_NONE;
                            r_d.st  = ST_IGNORE;
                        end
                    end else begin
                        r_d.st     = ST_ACK;
                        r_d.sda_oe = 1'b1;
                        if (r_q.tgt == TGT_CFG) begin
                            r_d.cfg_we = 1'b1;
                        end else if (!r_q.busy) begin
                            r_d.req_v = 1'b1;
                            r_d.req_w = 1'b1;
                            r_d.req_d = r_q.sh;
                            r_d.busy  = 1'b1;
                        end
                    end
                end
            end
            ST_ACK: begin
                if (scl_fall) begin
                    r_d.sda_oe = 1'b0;
                    if (stall) hold = 1'b1;
                    else       adv  = 1'b1;
                end
            end
            ST_TX: begin
                if (scl_fall) begin
                    if (r_q.cnt == CNT_LAST) begin
                        r_d.sda_oe = 1'b0;
                        r_d.st     = ST_TXACK;
                        r_d.cnt    = '0;
                    end else begin
                        r_d.sh     = {r_q.sh[BYTE_W-2:0], 1'b0};
                        r_d.cnt    = r_q.cnt + 1'b1;
                        r_d.sda_oe = ~r_q.sh[BYTE_W-2];
                    end
                end
            end
            ST_TXACK: begin
                if (scl_rise) begin
                    r_d.m_ack = ~sda_s;
                    if (!sda_s && r_q.tgt == TGT_MEM && !r_q.busy) begin
                        r_d.req_v = 1'b1;
                        r_d.req_w = 1'b0;
                        r_d.busy  = 1'b1;
                    end
                end else if (scl_fall) begin
                    if (!r_q.m_ack)  r_d.st = ST_IGNORE;
                    else if (stall)  hold   = 1'b1;
                    else             adv    = 1'b1;
                end
            end
            ST_HOLD: begin
                if (!r_q.busy || !stretch_en_i) begin
                    r_d.scl_oe = 1'b0;
                    adv        = 1'b1;
                end
            end
            default: ;
        endcase

        if (hold) begin
            r_d.st     = ST_HOLD;
            r_d.scl_oe = 1'b1;
        end

        if (adv) begin
            r_d.cnt = '0;
            if (r_q.rw) begin
                r_d.st     = ST_TX;
                r_d.sh     = tx_byte;
                r_d.sda_oe = ~tx_byte[BYTE_W-1];
            end else begin
                r_d.st = ST_RX;
                r_d.sh = '0;
            end
        end

        if (start_det) begin
            r_d.st      = ST_RX;
            r_d.addr_ph = 1'b1;
            r_d.tgt     = TGT_NONE;
            r_d.cnt     = '0;
            r_d.sh      = '0;
            r_d.sda_oe  = 1'b0;
            r_d.scl_oe  = 1'b0;
        end else if (stop_det) begin
            r_d.st     = ST_IDLE;
            r_d.sda_oe = 1'b0;
            r_d.scl_oe = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.st  <= ST_IDLE;
            r_q.tgt <= TGT_NONE;
        end else begin
            r_q <= r_d;
        end
    end

    assign scl_oe_o    = r_q.scl_oe;
    assign sda_oe_o    = r_q.sda_oe;
    assign req_valid_o = r_q.req_v;
    assign req_write_o = r_q.req_w;
    assign req_wdata_o = r_q.req_d;
    assign req_size_o  = cfg_size;

    // R10
    stretch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_oe_o && !stretch_en_i) |=> !scl_oe_o);

    // R7
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |=> !req_valid_o);

    // R6
    busy_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> cfg_val[CFG_BUSY_BIT]);

    // R11
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (!sda_oe_o && !scl_oe_o));
endmodule

// File: tb/sim_i2c_dual_slave.sv
module sim_i2c_dual_slave;
    localparam int H = 8;
    localparam logic [6:0] MEM_A = 7'h2A;
    localparam logic [6:0] CFG_A = 7'h51;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_oe, sda_oe, scl_bus, sda_bus;
    logic stretch_en = 1'b0;
    logic req_valid, req_write;
    logic [7:0] req_wdata;
    logic [1:0] req_size;
    logic rsp_valid = 1'b0;
    logic [7:0] rsp_rdata = '0;
    logic rsp_err = 1'b0, rsp_prot = 1'b0;

    int tests = 0, fails = 0;
    int lat = 4;
    int rd_cnt = 0, rd_exp = 0;
    int req_count = 0;
    logic inj_err = 1'b0, inj_prot = 1'b0;
    logic saw_stretch = 1'b0, saw_sda = 1'b0;
    logic [1:0] exp_size = 2'b00;
    logic [9:0] wr_q[$];

    always #5 clk = ~clk;

    assign scl_bus = scl_m & ~scl_oe;
    assign sda_bus = sda_m & ~sda_oe;

    i2c_dual_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
        .mem_addr_i(MEM_A), .cfg_addr_i(CFG_A), .stretch_en_i(stretch_en),
        .req_valid_o(req_valid), .req_write_o(req_write),
        .req_wdata_o(req_wdata), .req_size_o(req_size),
        .rsp_valid_i(rsp_valid), .rsp_rdata_i(rsp_rdata),
        .rsp_err_i(rsp_err), .rsp_prot_i(rsp_prot)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // local responder
    initial begin
        forever begin
            @(negedge clk);
            if (req_valid) begin
                logic w;
                w = req_write;
                repeat (lat) @(negedge clk);
                rsp_valid = 1'b1;
                rsp_rdata = w ? 8'h00 : 8'(8'hA0 + rd_cnt);
                if (!w) rd_cnt++;
                rsp_err  = inj_err;
                rsp_prot = inj_prot;
                @(negedge clk);
                rsp_valid = 1'b0;
            end
        end
    end

    // scoreboard monitor for write requests (R7)
    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_oe) saw_stretch = 1'b1;
            if (sda_oe) saw_sda = 1'b1;
            if (req_valid) begin
                req_count++;
                if (req_write) begin
                    if (wr_q.size() == 0) check("R7 unexpected write", {22'd0, req_size, req_wdata}, 32'hFFFF);
                    else begin
                        logic [9:0] e;
                        e = wr_q.pop_front();
                        check("R7 write data/size", {22'd0, req_size, req_wdata}, {22'd0, e});
                    end
                end
            end
        end
    end

    task automatic wait_h();
        repeat (H) @(negedge clk);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;
        wait_h();
        scl_m = 1'b1;
        wait (scl_bus == 1'b1);
        @(negedge clk);
        wait_h();
        scl_m = 1'b0;
        wait_h();
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1;
        wait_h();
        scl_m = 1'b1;
        wait (scl_bus == 1'b1);
        @(negedge clk);
        repeat (H/2) @(negedge clk);
        b = sda_bus;
        repeat (H/2) @(negedge clk);
        scl_m = 1'b0;
        wait_h();
    endtask

    task automatic put_byte(input logic [7:0] v, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(a);
        acked = ~a;
    endtask

    task automatic get_byte(input logic ack_it, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        put_bit(~ack_it);
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        wait_h();
        scl_m = 1'b1;
        wait (scl_bus == 1'b1);
        @(negedge clk);
        wait_h();
        sda_m = 1'b0;
        wait_h();
        scl_m = 1'b0;
        wait_h();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        wait_h();
        scl_m = 1'b1;
        wait (scl_bus == 1'b1);
        @(negedge clk);
        wait_h();
        sda_m = 1'b1;
        wait_h();
    endtask

    task automatic cfg_write(input logic [7:0] v);
        logic a;
        bus_start();
        put_byte({CFG_A, 1'b0}, a);
        check("R1 cfg write address ack", a, 1'b1);
        put_byte(v, a);
        check("R3 cfg data ack", a, 1'b1);
        bus_stop();
    endtask

    task automatic cfg_read(output logic [7:0] v);
        logic a;
        bus_start();
        put_byte({CFG_A, 1'b1}, a);
        check("R1 cfg read address ack", a, 1'b1);
        get_byte(1'b0, v);
        bus_stop();
    endtask

    task automatic mem_write1(input logic [7:0] v);
        logic a;
        wr_q.push_back({exp_size, v});
        bus_start();
        put_byte({MEM_A, 1'b0}, a);
        check("R1 mem write address ack", a, 1'b1);
        put_byte(v, a);
        check("R7 mem data ack", a, 1'b1);
        bus_stop();
    endtask

    task automatic mem_read(input int n);
        logic a;
        logic [7:0] v;
        bus_start();
        put_byte({MEM_A, 1'b1}, a);
        check("R1 mem read address ack", a, 1'b1);
        for (int k = 0; k < n; k++) begin
            get_byte(k != n - 1, v);
            check("R8 read byte", v, 8'(8'hA0 + rd_exp));
            rd_exp++;
        end
        bus_stop();
    endtask

    initial begin
        logic a;
        logic [7:0] v;
        int cnt0;
        repeat (5) @(negedge clk);
        // R12 reset state
        check("R12 sda released", sda_oe, 1'b0);
        check("R12 scl released", scl_oe, 1'b0);
        check("R12 no request", req_valid, 1'b0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        cfg_read(v);
        check("R12 cfg reset value", v, 8'h00);

        // R3: only bits 2:0 stored, reserved reads zero
        cfg_write(8'hC9);
        cfg_read(v);
        check("R3 ctl bits from 0xC9", v, 8'h01);
        cfg_write(8'hFA);
        cfg_read(v);
        check("R4 cfg layout after 0xFA", v, 8'h02);
        exp_size = 2'b10;

        // R7 multi-byte memory write
        wr_q.push_back({exp_size, 8'h3C});
        wr_q.push_back({exp_size, 8'hC3});
        bus_start();
        put_byte({MEM_A, 1'b0}, a);
        check("R1 mem address ack", a, 1'b1);
        put_byte(8'h3C, a);
        check("R7 byte 1 ack", a, 1'b1);
        put_byte(8'hC3, a);
        check("R7 byte 2 ack", a, 1'b1);
        bus_stop();

        // R8 memory read, three bytes
        mem_read(3);

        // R2 address mismatch
        cnt0 = req_count;
        bus_start();
        saw_sda = 1'b0;
        put_byte({7'h10, 1'b0}, a);
        check("R2 mismatch not acked", a, 1'b0);
        put_byte(8'h00, a);
        check("R2 ignored byte not acked", a, 1'b0);
        check("R2 no sda drive while ignoring", saw_sda, 1'b0);
        check("R2 no request while ignoring", 32'(req_count - cnt0), 32'd0);
        bus_stop();

        // R11 repeated start from memory write to cfg read
        wr_q.push_back({exp_size, 8'h11});
        bus_start();
        put_byte({MEM_A, 1'b0}, a);
        put_byte(8'h11, a);
        check("R7 byte before restart ack", a, 1'b1);
        bus_start();
        put_byte({CFG_A, 1'b1}, a);
        check("R11 cfg address after restart", a, 1'b1);
        get_byte(1'b0, v);
        check("R11 cfg read after restart", v, 8'h02);
        bus_stop();

        // R9 no-ack control
        cfg_write(8'h06);
        bus_start();
        put_byte({MEM_A, 1'b0}, a);
        check("R9 mem address refused", a, 1'b0);
        bus_stop();
        cfg_read(v);
        check("R9 cfg still answers", v, 8'h06);
        cfg_write(8'h02);

        // R5 fault flags follow each response
        inj_err = 1'b1; inj_prot = 1'b0;
        mem_write1(8'h55);
        cfg_read(v);
        check("R5 error flag", v, 8'h12);
        inj_err = 1'b0; inj_prot = 1'b1;
        mem_write1(8'h56);
        cfg_read(v);
        check("R5 window flag", v, 8'h22);
        inj_prot = 1'b0;
        mem_write1(8'h57);
        cfg_read(v);
        check("R5 flags cleared", v, 8'h02);

        // R6 busy flag with slow local side, no stretching
        lat = 300;
        saw_stretch = 1'b0;
        wr_q.push_back({exp_size, 8'h77});
        bus_start();
        put_byte({MEM_A, 1'b0}, a);
        put_byte(8'h77, a);
        check("R7 slow write ack", a, 1'b1);
        bus_start();
        put_byte({CFG_A, 1'b1}, a);
        get_byte(1'b0, v);
        check("R6 busy while outstanding", v, 8'h0A);
        bus_stop();
        repeat (400) @(negedge clk);
        cfg_read(v);
        check("R6 busy cleared", v, 8'h02);
        check("R10 no stretch when disabled", saw_stretch, 1'b0);

        // R10 stretching with slow local side
        stretch_en = 1'b1;
        lat = 100;
        saw_stretch = 1'b0;
        mem_read(2);
        check("R10 stretch seen on read", saw_stretch, 1'b1);
        saw_stretch = 1'b0;
        mem_write1(8'h9E);
        check("R10 stretch seen on write", saw_stretch, 1'b1);
        repeat (200) @(negedge clk);

        check("R7 scoreboard drained", 32'(wr_q.size()), 32'd0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule